// File: doc/BRIEF.md
# Ping-Pong Audio Sample Buffer

This block sits between a codec's parallel sample port and a processor register bus. It holds 16-bit audio in two rings. Each ring is split into two equal halves. A programmable divider makes a sample strobe. On each strobe, while sampling is enabled, one microphone word is taken into the capture ring and one speaker word leaves the playback ring.

When a capture half fills, the block flags it. The next samples keep landing in the other half, so the processor has a full half-period to empty the finished half. On the playback side, the block flags the moment a half has been sent out, so software can refill that half. Both directions share the same strobe, so their half events raise one interrupt line.

Four word registers sit on a 2-bit address:
- 0 is the data port: reads take microphone words, writes queue speaker words.
- 1 is control: bit 0 enables sampling.
- 2 is status: write 1 to a bit to clear it.
- 3 is the divider.

Top module: `audio_pingpong_fifo`

## Requirements
- R1: After reset, irq is 0, spk_sample is 0, sample_tick is 0, and the status register reads 0.
- R2: While control bit 0 is 1, sample_tick is high for one cycle every DIV+1 cycles, where DIV is the value in register 3. While control bit 0 is 0, sample_tick stays low.
- R3: Each strobe stores mic_sample in the capture ring. A read of register 0 returns the oldest stored word and removes it. A read of an empty ring returns 0.
- R4: When a strobe stores the last word of a capture half, status bit 0 (capture pending) is set. Status bit 4 then holds the index of that half: 0 for the lower half, 1 for the upper.
- R5: While capture is pending, later strobes fill the other half. All stored words read out in arrival order across both halves.
- R6: If a strobe finds the capture ring full (two halves), the new word is dropped and status bit 2 (overflow) is set. The stored words are kept.
- R7: Writes to register 0 queue speaker words. Each strobe moves the oldest queued word to spk_sample, in write order.
- R8: When a strobe sends the last word of a playback half, status bit 1 (playback pending) is set. Status bit 5 then holds the index of that half.
- R9: A strobe with the playback ring empty drives spk_sample to 0 and sets status bit 2+1 = bit 3 (underflow).
- R10: Writing register 2 clears every status bit 0..3 whose write bit is 1. Bits written 0 keep their value. irq is high exactly while bit 0 or bit 1 is set.
- R11: A write to register 0 while the playback ring is full is discarded. That word never reaches spk_sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops data port) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for current address |
| mic_sample | input | 16 | Microphone word from codec |
| sample_tick | output | 1 | Sample strobe to codec |
| spk_sample | output | 16 | Speaker word to codec |
| irq | output | 1 | Combined half-buffer interrupt |

## Verification
If a ring pointer or level goes wrong, it shows at the data port on the very next read: words come back out of order, repeated, or as zero while data is still stored. A bad half-boundary decode shows at the first strobe that crosses a boundary: the pending bit or the half index in status is wrong, and irq is wrong in the following cycle. Playback faults show in the spk_sample word that follows each strobe. The divider is measured as the exact count of cycles between strobes.

// File: rtl/audio_fifo_pkg.sv
package audio_fifo_pkg;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_CTRL = 2'd1,
        REG_STAT = 2'd2,
        REG_RATE = 2'd3
    } reg_sel_e;

    // Status word, packed so bit 0 is cap_pend and bit 5 is play_half.
    typedef struct packed {
        logic play_half;
        logic cap_half;
        logic play_under;
        logic cap_over;
        logic play_pend;
        logic cap_pend;
    } status_t;

    localparam int STAT_W = $bits(status_t);

    // True when idx is the last slot of a half of size half (a power of two).
    function automatic logic last_in_half(input logic [31:0] idx, input int half);
        return (idx & 32'(half - 1)) == 32'(half - 1);
    endfunction

endpackage

// File: rtl/rate_divider.sv
module rate_divider #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sample_ring.sv
module sample_ring
    import audio_fifo_pkg::*;
#(
    parameter int W          = 16,
    parameter int HALF       = 128,
    parameter bit WATCH_FILL = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty,
    output logic         half_evt,
    output logic         half_idx
);
    localparam int DEPTH = 2 * HALF;
    localparam int PW    = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [PW:0]   level;

    assign head  = mem[rd_ptr];
    assign full  = (level == (PW+1)'(DEPTH));
    assign empty = (level == '0);

    generate
        if (WATCH_FILL) begin : g_fill
            assign half_evt = push && last_in_half(32'(wr_ptr), HALF);
            assign half_idx = wr_ptr[PW-1];
        end else begin : g_drain
            assign half_evt = pop && last_in_half(32'(rd_ptr), HALF);
            assign half_idx = rd_ptr[PW-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/audio_pingpong_fifo.sv
module audio_pingpong_fifo
    import audio_fifo_pkg::*;
#(
    parameter int W     = 16,
    parameter int HALF  = 128,
    parameter int DIV_W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   bus_addr,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] mic_sample,
    output logic         sample_tick,
    output logic [W-1:0] spk_sample,
    output logic         irq
);
    logic             run_q;
    logic [DIV_W-1:0] div_q;
    status_t          stat_q, stat_d, clr;
    logic [W-1:0]     spk_q;

    logic [W-1:0] cap_head, play_head;
    logic         cap_full, cap_empty, play_full, play_empty;
    logic         cap_evt, cap_idx, play_evt, play_idx;
    logic         cap_push, cap_pop, play_push, play_pop;
    logic         sel_data, sel_ctrl, sel_stat, sel_rate;

    assign sel_data = (reg_sel_e'(bus_addr) == REG_DATA);
    assign sel_ctrl = (reg_sel_e'(bus_addr) == REG_CTRL);
    assign sel_stat = (reg_sel_e'(bus_addr) == REG_STAT);
    assign sel_rate = (reg_sel_e'(bus_addr) == REG_RATE);

    rate_divider #(.DIV_W(DIV_W)) div_i (
        .clk  (clk),
        .rst  (rst),
        .run  (run_q),
        .div  (div_q),
        .tick (sample_tick)
    );

    assign cap_push  = sample_tick && !cap_full;
    assign cap_pop   = bus_rd && sel_data && !cap_empty;
    assign play_push = bus_wr && sel_data && !play_full;
    assign play_pop  = sample_tick && !play_empty;

    sample_ring #(.W(W), .HALF(HALF), .WATCH_FILL(1'b1)) cap_i (
        .clk       (clk),
        .rst       (rst),
        .push      (cap_push),
        .push_data (mic_sample),
        .pop       (cap_pop),
        .head      (cap_head),
        .full      (cap_full),
        .empty     (cap_empty),
        .half_evt  (cap_evt),
        .half_idx  (cap_idx)
    );

    sample_ring #(.W(W), .HALF(HALF), .WATCH_FILL(1'b0)) play_i (
        .clk       (clk),
        .rst       (rst),
        .push      (play_push),
        .push_data (bus_wdata),
        .pop       (play_pop),
        .head      (play_head),
        .full      (play_full),
        .empty     (play_empty),
        .half_evt  (play_evt),
        .half_idx  (play_idx)
    );

    // Status update: new events win over a same-cycle clear.
    always_comb begin
        clr    = (bus_wr && sel_stat) ? status_t'(bus_wdata[STAT_W-1:0]) : '0;
        stat_d = stat_q;
        stat_d.cap_pend   = (stat_q.cap_pend   && !clr.cap_pend)   || cap_evt;
        stat_d.play_pend  = (stat_q.play_pend  && !clr.play_pend)  || play_evt;
        stat_d.cap_over   = (stat_q.cap_over   && !clr.cap_over)   || (sample_tick && cap_full);
        stat_d.play_under = (stat_q.play_under && !clr.play_under) || (sample_tick && play_empty);
        if (cap_evt)  stat_d.cap_half  = cap_idx;
        if (play_evt) stat_d.play_half = play_idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            div_q  <= '0;
            stat_q <= '0;
            spk_q  <= '0;
        end else begin
            stat_q <= stat_d;
            if (bus_wr && sel_ctrl) run_q <= bus_wdata[0];
            if (bus_wr && sel_rate) div_q <= bus_wdata[DIV_W-1:0];
            if (sample_tick) spk_q <= play_empty ? '0 : play_head;
        end
    end

    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            REG_DATA: bus_rdata = cap_empty ? '0 : cap_head;
            REG_CTRL: bus_rdata = W'(run_q);
            REG_STAT: bus_rdata = W'(stat_q);
            default:  bus_rdata = W'(div_q);
        endcase
    end

    assign spk_sample = spk_q;
    assign irq        = stat_q.cap_pend || stat_q.play_pend;
endmodule

// File: rtl/audio_fifo_chk.sv
module audio_fifo_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         run,
    input logic         sample_tick,
    input logic         cap_full,
    input logic         play_empty,
    input logic [5:0]   stat,
    input logic [W-1:0] spk_sample,
    input logic         irq,
    input logic         bus_wr,
    input logic [1:0]   bus_addr,
    input logic [W-1:0] bus_wdata
);
    // R2
    tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !run |-> !sample_tick);

    // R6
    cap_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        sample_tick && cap_full |=> stat[2]);

    // R9
    play_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        sample_tick && play_empty |=> (spk_sample == '0) && stat[3]);

    // R10
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        bus_wr && (bus_addr == 2'd2) && (bus_wdata[1:0] == 2'b11) && !sample_tick |=> !irq);
endmodule

bind audio_pingpong_fifo audio_fifo_chk #(.W(W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .run         (run_q),
    .sample_tick (sample_tick),
    .cap_full    (cap_full),
    .play_empty  (play_empty),
    .stat        (stat_q),
    .spk_sample  (spk_sample),
    .irq         (irq),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata)
);

// File: tb/audio_pingpong_fifo_tb.sv
`timescale 1ns/1ps
module audio_pingpong_fifo_tb_top;
    localparam int W    = 16;
    localparam int HALF = 4;
    localparam logic [15:0] MIC_BASE = 16'h1000;
    localparam logic [15:0] SPK_BASE = 16'h5000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] mic_sample = '0;
    logic         sample_tick;
    logic [W-1:0] spk_sample;
    logic         irq;

    int tests = 0;
    int fails = 0;
    int ticks_seen = 0;
    int spk_n = 0;
    int cycles = 0;
    logic prev_tick = 1'b0;
    logic [W-1:0] spk_log [64];

    always #2.5 clk = ~clk;

    audio_pingpong_fifo #(.W(W), .HALF(HALF), .DIV_W(12)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mic_sample(mic_sample),
        .sample_tick(sample_tick), .spk_sample(spk_sample), .irq(irq)
    );

    // Codec model: present word k for strobe k, log speaker word after each strobe.
    always @(negedge clk) begin
        if (prev_tick && spk_n < 64) begin
            spk_log[spk_n] = spk_sample;
            spk_n++;
        end
        prev_tick = sample_tick;
        if (sample_tick) begin
            mic_sample = MIC_BASE + 16'(ticks_seen);
            ticks_seen++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int got, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic run_until(input int target);
        bus_write(2'd1, 16'd1);
        while (ticks_seen < target) @(posedge clk);
        bus_write(2'd1, 16'd0);
    endtask

    task automatic measure_period(output int p);
        p = 0;
        @(negedge clk);
        while (!sample_tick) @(negedge clk);
        do begin
            @(negedge clk);
            p++;
        end while (!sample_tick && p < 100);
    endtask

    initial begin
        logic [W-1:0] rd;
        int mark, per, quiet;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(irq == 1'b0, "R1 irq", int'(irq), 0);
        check(spk_sample == '0, "R1 spk", int'(spk_sample), 0);
        check(sample_tick == 1'b0, "R1 tick", int'(sample_tick), 0);
        bus_read(2'd2, rd);
        check(rd == '0, "R1 status", int'(rd), 0);

        bus_write(2'd3, 16'd3);
        bus_read(2'd3, rd);
        check(rd == 16'd3, "R2 divider readback", int'(rd), 3);

        // Capture: first half
        run_until(4);
        bus_read(2'd2, rd);
        check(rd[0] == 1'b1 && rd[4] == 1'b0, "R4 lower half pending", int'(rd), 16'h0001);
        check(irq == 1'b1, "R10 irq on pending", int'(irq), 1);
        check(rd[3] == 1'b1, "R9 underflow flag", int'(rd), 16'h0008);
        for (int i = 0; i < 4; i++)
            check(spk_log[i] == '0, "R9 zero speaker", int'(spk_log[i]), 0);

        // Keep filling the other half while pending
        run_until(7);
        check(irq == 1'b1, "R5 still pending", int'(irq), 1);
        bus_write(2'd2, 16'h0001);
        @(negedge clk);
        check(irq == 1'b0, "R10 clear pending", int'(irq), 0);
        for (int i = 0; i < 4; i++) begin
            bus_read(2'd0, rd);
            check(rd == MIC_BASE + 16'(i), "R3 capture order", int'(rd), int'(MIC_BASE) + i);
        end
        run_until(8);
        bus_read(2'd2, rd);
        check(rd[0] == 1'b1 && rd[4] == 1'b1, "R5 upper half pending", int'(rd), 16'h0011);
        for (int i = 4; i < 8; i++) begin
            bus_read(2'd0, rd);
            check(rd == MIC_BASE + 16'(i), "R5 second half order", int'(rd), int'(MIC_BASE) + i);
        end
        bus_read(2'd0, rd);
        check(rd == '0, "R3 empty read", int'(rd), 0);
        bus_write(2'd2, 16'h003F);

        // Overflow: nine strobes into an eight-word ring
        run_until(17);
        bus_read(2'd2, rd);
        check(rd[2] == 1'b1, "R6 overflow flag", int'(rd), 16'h0004);
        for (int i = 8; i < 16; i++) begin
            bus_read(2'd0, rd);
            check(rd == MIC_BASE + 16'(i), "R6 kept words", int'(rd), int'(MIC_BASE) + i);
        end
        bus_read(2'd0, rd);
        check(rd == '0, "R6 newest dropped", int'(rd), 0);
        bus_write(2'd2, 16'h003F);
        bus_read(2'd2, rd);
        check(rd[3:0] == 4'h0, "R10 clear all", int'(rd[3:0]), 0);

        // Playback: nine writes, last one discarded
        for (int i = 0; i < 9; i++) bus_write(2'd0, SPK_BASE + 16'(i));
        mark = spk_n;
        run_until(21);
        bus_read(2'd2, rd);
        check(rd[1] == 1'b1 && rd[5] == 1'b0, "R8 lower half sent", int'(rd), 16'h0002);
        bus_write(2'd2, 16'h0003);
        @(negedge clk);
        check(irq == 1'b0, "R10 clear both", int'(irq), 0);
        run_until(25);
        bus_read(2'd2, rd);
        check(rd[1] == 1'b1 && rd[5] == 1'b1, "R8 upper half sent", int'(rd), 16'h0022);
        check(rd[3] == 1'b0, "R9 no underflow yet", int'(rd), 0);
        run_until(26);
        for (int i = 0; i < 8; i++)
            check(spk_log[mark+i] == SPK_BASE + 16'(i), "R7 playback order",
                  int'(spk_log[mark+i]), int'(SPK_BASE) + i);
        check(spk_log[mark+8] == '0, "R11 extra write discarded", int'(spk_log[mark+8]), 0);
        bus_write(2'd2, 16'h0000);
        bus_read(2'd2, rd);
        check(rd[3] == 1'b1, "R10 zero write keeps bit", int'(rd), 16'h0008);

        // Divider sweep
        foreach (per_vals[k]) begin
            bus_write(2'd3, 16'(per_vals[k]));
            bus_write(2'd1, 16'd1);
            measure_period(per);
            check(per == per_vals[k] + 1, "R2 strobe period", per, per_vals[k] + 1);
            bus_write(2'd1, 16'd0);
        end
        quiet = 0;
        repeat (30) begin
            @(negedge clk);
            if (sample_tick) quiet++;
        end
        check(quiet == 0, "R2 no strobe when stopped", quiet, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    int per_vals [5] = '{0, 1, 2, 5, 9};
endmodule